// File: doc/BRIEF.md
# Four-Channel Wiper Register Serial Controller

This block is the digital front end of a four-channel digitally controlled potentiometer. A host drives it as an SPI-style slave (clock, active-low select, serial in, serial out). For each channel it keeps one 8-bit wiper code and four 8-bit data registers. The four wiper codes are driven out in parallel to the analog side, which is not part of this block. The data registers stand in for nonvolatile storage: they are plain flops, and after each store a busy period runs for a set number of cycles.

The serial inputs are sampled in the system clock domain. Each SCK edge is detected by comparing SCK with its value one clock earlier. Every command starts with an addressing byte and then an instruction byte. Depending on the opcode, a data byte follows, or an open-ended stream of step pulses. In the stream, each SCK pulse moves the selected wiper up or down by one, according to SI.

Top module: `quad_wiper_spi`

## Requirements
- R1: Byte 0 of a transaction holds an identifier in bits [7:4], which must equal parameter DEV_ID (default 4'h5), and an address in bits [1:0], which must equal the `dev_addr` strap. Bits [3:2] are ignored. On a mismatch, the rest of the transaction changes no register and never enables SO.
- R2: Byte 1 holds the opcode in bits [7:4], the data-register select in bits [3:2] and the channel select in bits [1:0]. The opcodes are: 9 read wiper, A write wiper, B read data register, C write data register, D copy data register to wiper, E copy wiper to data register, 2 step mode.
- R3: SI is sampled on the rising edge of SCK, MSB first. A command acts only after its last byte is complete: two bytes for copies, three for reads and writes. Raising CS earlier changes no register.
- R4: A write command (A or C) loads the third byte into the selected wiper or data register.
- R5: A read command (9 or B) drives the selected register onto SO, MSB first, with each bit launched on an SCK falling edge. The first bit is launched on the falling edge after byte 1. `so_oe` is high only while those eight bits are on the line.
- R6: Opcode D copies the selected data register into the channel's wiper. Opcode E copies the channel's wiper into the selected data register.
- R7: In step mode, each rising SCK edge after byte 1, until CS rises, adds one to the wiper if SI is 1 and subtracts one if SI is 0. The wiper saturates at FFh and at 00h.
- R8: While `hold_n` is low, SCK edges are ignored, no register changes and `so_oe` is low. When `hold_n` returns high, the transaction resumes where it stopped.
- R9: While `wp_n` is low, no wiper or data register changes. Reads still work.
- R10: Every data-register store (opcode C or E) raises `busy` for BUSY_CYCLES clock cycles. Stores that complete while `busy` is high are dropped.
- R11: After reset, all wipers and data registers are 00h, and `busy` and `so_oe` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low transaction select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause of shifting |
| wp_n | input | 1 | Active-low write protect |
| dev_addr | input | 2 | Address strap compared with byte 0 |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for SO (high impedance when low) |
| busy | output | 1 | Data-register store in progress |
| wiper | output | 32 | Four wiper codes, channel n at bits [8n+7:8n] |

## Verification
The bench goes after five corner cases:
- **Saturation.** It steps past both ends of the code range. A design that wraps would show 00h after FFh, or FFh after 00h.
- **Early abort.** It raises CS part-way through the data byte. A design that acts on a partial count would load a truncated value.
- **HOLD.** It pulses SCK with HOLD low in the middle of a command. A design that does not gate SCK with HOLD would shift in the junk bits and write the wrong register.
- **Blocked stores.** It issues stores under write protect and while busy. A design missing either gate would overwrite the register.
- **Read-back.** Reads of every register kind are compared bit by bit. An SO path that is off by one edge would return the value shifted by one place.

// File: rtl/quad_wiper_spi.sv
module quad_wiper_spi #(
  parameter int BUSY_CYCLES = 64,
  parameter logic [3:0] DEV_ID = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck,
  input  logic        cs_n,
  input  logic        si,
  input  logic        hold_n,
  input  logic        wp_n,
  input  logic [1:0]  dev_addr,
  output logic        so,
  output logic        so_oe,
  output logic        busy,
  output logic [31:0] wiper
);
  localparam int BW = $clog2(BUSY_CYCLES + 1);
  localparam logic [3:0] OP_RD_W = 4'h9, OP_WR_W = 4'hA, OP_RD_D = 4'hB,
                         OP_WR_D = 4'hC, OP_D2W  = 4'hD, OP_W2D  = 4'hE,
                         OP_STEP = 4'h2;

  logic          sck_q, dev_ok, so_en;
  logic [4:0]    cnt;
  logic [7:0]    sh, soreg;
  logic [3:0]    op;
  logic [1:0]    rs, ps;
  logic [BW-1:0] bcnt;
  logic [7:0]    wcr [4];
  logic [7:0]    dr  [4][4];

  wire       rise = !cs_n && hold_n && sck && !sck_q;
  wire       fall = !cs_n && hold_n && !sck && sck_q;
  wire [7:0] nxt  = {sh[6:0], si};

  assign busy  = bcnt != '0;
  assign so    = soreg[7];
  assign so_oe = so_en && hold_n && !cs_n;

  for (genvar i = 0; i < 4; i++) begin : g_out
    assign wiper[8*i +: 8] = wcr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q  <= 1'b0;
      dev_ok <= 1'b0;
      so_en  <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
      soreg  <= '0;
      op     <= '0;
      rs     <= '0;
      ps     <= '0;
      bcnt   <= '0;
      for (int c = 0; c < 4; c++) begin
        wcr[c] <= '0;
        for (int r = 0; r < 4; r++) dr[c][r] <= '0;
      end
    end else begin
      sck_q <= sck;
      if (busy) bcnt <= bcnt - 1'b1;
      if (cs_n) begin
        cnt    <= '0;
        dev_ok <= 1'b0;
        so_en  <= 1'b0;
      end else begin
        if (rise) begin
          sh <= nxt;
          if (cnt != 5'd24) cnt <= cnt + 5'd1;
          if (cnt == 5'd7) dev_ok <= (nxt[7:4] == DEV_ID) && (nxt[1:0] == dev_addr);
          if (cnt == 5'd15) begin
            op <= nxt[7:4];
            rs <= nxt[3:2];
            ps <= nxt[1:0];
            if (dev_ok && wp_n) begin
              if (nxt[7:4] == OP_D2W)
                wcr[nxt[1:0]] <= dr[nxt[1:0]][nxt[3:2]];
              else if (nxt[7:4] == OP_W2D && !busy) begin
                dr[nxt[1:0]][nxt[3:2]] <= wcr[nxt[1:0]];
                bcnt <= BW'(BUSY_CYCLES);
              end
            end
          end
          if (cnt == 5'd23 && dev_ok && wp_n) begin
            if (op == OP_WR_W)
              wcr[ps] <= nxt;
            else if (op == OP_WR_D && !busy) begin
              dr[ps][rs] <= nxt;
              bcnt <= BW'(BUSY_CYCLES);
            end
          end
          if (cnt >= 5'd16 && dev_ok && wp_n && op == OP_STEP) begin
            if (si && wcr[ps] != 8'hFF)       wcr[ps] <= wcr[ps] + 8'd1;
            else if (!si && wcr[ps] != 8'h00) wcr[ps] <= wcr[ps] - 8'd1;
          end
        end
        if (fall) begin
          if (cnt == 5'd16 && dev_ok && (op == OP_RD_W || op == OP_RD_D)) begin
            soreg <= (op == OP_RD_W) ? wcr[ps] : dr[ps][rs];
            so_en <= 1'b1;
          end else if (so_en) begin
            soreg <= {soreg[6:0], 1'b0};
            if (cnt == 5'd24) so_en <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/quad_wiper_spi_chk.sv
module quad_wiper_spi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        hold_n,
  input logic        wp_n,
  input logic        so_oe,
  input logic        busy,
  input logic [31:0] wiper
);
  a_r8_hold_freezes_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |=> $stable(wiper));
  a_r9_wp_freezes_wiper: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> $stable(wiper));
  a_r3_idle_cs_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> $stable(wiper));
  a_r5_oe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (!cs_n && hold_n));
  a_r8_oe_low_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_n |-> !so_oe);
  a_r10_busy_rises_in_transaction: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(!cs_n && wp_n));
endmodule

bind quad_wiper_spi quad_wiper_spi_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .hold_n(hold_n), .wp_n(wp_n),
  .so_oe(so_oe), .busy(busy), .wiper(wiper)
);

// File: tb/quad_wiper_spi_tb.sv
module quad_wiper_spi_tb;
  localparam int BUSY = 600;
  localparam logic [3:0] ID = 4'h5;
  localparam logic [1:0] ADDR = 2'b10;

  logic clk = 0, rst_n = 0, sck = 0, cs_n = 1, si = 0, hold_n = 1, wp_n = 1;
  logic [1:0] dev_addr = ADDR;
  logic so, so_oe, busy;
  logic [31:0] wiper;

  quad_wiper_spi #(.BUSY_CYCLES(BUSY), .DEV_ID(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
    .wp_n(wp_n), .dev_addr(dev_addr), .so(so), .so_oe(so_oe), .busy(busy), .wiper(wiper));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_w [4];
  logic [7:0] m_d [4][4];
  logic oe_seen;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] sat(input logic [7:0] v, input logic up);
    if (up) return (v == 8'hFF) ? v : v + 8'd1;
    return (v == 8'h00) ? v : v - 8'd1;
  endfunction

  function automatic logic [31:0] mw();
    return {m_w[3], m_w[2], m_w[1], m_w[0]};
  endfunction

  task automatic sbit(input logic b, output logic s);
    @(negedge clk); sck = 0; si = b;
    repeat (3) @(negedge clk);
    s = so;
    if (so_oe) oe_seen = 1;
    sck = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic s;
      sbit(tx[i], s);
      rx[i] = s;
    end
  endtask

  task automatic start(); @(negedge clk); cs_n = 0; repeat (2) @(negedge clk); endtask
  task automatic stop();  @(negedge clk); cs_n = 1; sck = 0; repeat (3) @(negedge clk); endtask

  task automatic cmd(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                     input logic [7:0] data, input logic [1:0] a, output logic [7:0] rd);
    logic [7:0] dmy;
    start();
    sbyte({ID, 2'b00, a}, dmy);
    sbyte({op, r, p}, dmy);
    oe_seen = 0;
    rd = '0;
    if (op inside {4'h9, 4'hA, 4'hB, 4'hC}) sbyte(data, rd);
    stop();
  endtask

  task automatic model(input logic [3:0] op, input logic [1:0] r, input logic [1:0] p,
                       input logic [7:0] data, output logic [7:0] exp);
    exp = (op == 4'h9) ? m_w[p] : m_d[p][r];
    if (wp_n) case (op)
      4'hA: m_w[p] = data;
      4'hC: m_d[p][r] = data;
      4'hD: m_w[p] = m_d[p][r];
      4'hE: m_d[p][r] = m_w[p];
      default: ;
    endcase
  endtask

  task automatic step(input logic [1:0] p, input int n, input logic [31:0] dirs);
    logic [7:0] dmy;
    logic s;
    start();
    sbyte({ID, 2'b00, ADDR}, dmy);
    sbyte({4'h2, 2'b00, p}, dmy);
    for (int i = 0; i < n; i++) begin
      sbit(dirs[i], s);
      if (wp_n) m_w[p] = sat(m_w[p], dirs[i]);
    end
    stop();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, ex, dmy;
    logic s;
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4; c++) begin
      m_w[c] = 0;
      for (int r = 0; r < 4; r++) m_d[c][r] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R11 reset state
    check(wiper == 0 && !busy && !so_oe, "R11 reset", {wiper[28:0], busy, so_oe, 1'b0}, 0);

    // R4 write wiper, R5 read back
    cmd(4'hA, 2'd0, 2'd1, 8'hA5, ADDR, rd); model(4'hA, 0, 1, 8'hA5, ex);
    check(wiper == mw(), "R4 write wiper", wiper, mw());
    cmd(4'h9, 2'd0, 2'd1, 8'h00, ADDR, rd);
    check(rd == 8'hA5 && oe_seen, "R5 read wiper", rd, 8'hA5);
    check(!so_oe, "R5 oe idle", so_oe, 0);

    // R1 address mismatch
    cmd(4'hA, 2'd0, 2'd1, 8'h3C, ~ADDR, rd);
    check(wiper == mw(), "R1 wrong address ignored", wiper, mw());
    cmd(4'h9, 2'd0, 2'd1, 8'h00, ~ADDR, rd);
    check(!oe_seen, "R1 no SO on mismatch", oe_seen, 0);

    // R7 saturation
    cmd(4'hA, 0, 2, 8'hFD, ADDR, rd); model(4'hA, 0, 2, 8'hFD, ex);
    step(2, 5, 32'h1F);
    check(wiper == mw() && wiper[23:16] == 8'hFF, "R7 saturate high", wiper, mw());
    cmd(4'hA, 0, 2, 8'h02, ADDR, rd); model(4'hA, 0, 2, 8'h02, ex);
    step(2, 5, 32'h0);
    check(wiper[23:16] == 8'h00, "R7 saturate low", wiper[23:16], 0);

    // R3 abort mid data byte
    start(); sbyte({ID, 2'b00, ADDR}, dmy); sbyte({4'hA, 2'b00, 2'd1}, dmy);
    for (int i = 0; i < 5; i++) sbit(1'b1, s);
    stop();
    check(wiper == mw(), "R3 abort keeps wiper", wiper, mw());

    // R8 hold mid command
    start(); sbyte({ID, 2'b00, ADDR}, dmy);
    @(negedge clk); hold_n = 0;
    for (int i = 0; i < 3; i++) sbit(1'b1, s);
    check(!so_oe, "R8 oe low in hold", so_oe, 0);
    @(negedge clk); hold_n = 1;
    sbyte({4'hA, 2'b00, 2'd3}, dmy); sbyte(8'h5A, dmy); stop();
    model(4'hA, 0, 3, 8'h5A, ex);
    check(wiper == mw(), "R8 hold resume", wiper, mw());

    // R9 write protect
    wp_n = 0;
    cmd(4'hA, 0, 3, 8'h11, ADDR, rd); model(4'hA, 0, 3, 8'h11, ex);
    check(wiper == mw(), "R9 wp blocks write", wiper, mw());
    cmd(4'h9, 0, 3, 0, ADDR, rd);
    check(rd == 8'h5A, "R9 read under wp", rd, 8'h5A);
    wp_n = 1;

    // R10 busy and dropped store, R6 copy back
    cmd(4'hC, 2'd2, 2'd0, 8'h77, ADDR, rd); model(4'hC, 2, 0, 8'h77, ex);
    check(busy, "R10 busy after store", busy, 1);
    cmd(4'hC, 2'd2, 2'd0, 8'h99, ADDR, rd);
    cmd(4'hB, 2'd2, 2'd0, 0, ADDR, rd);
    check(rd == 8'h77, "R10 store while busy dropped", rd, 8'h77);
    repeat (BUSY) @(negedge clk);
    check(!busy, "R10 busy ends", busy, 0);
    cmd(4'hD, 2'd2, 2'd0, 0, ADDR, rd); model(4'hD, 2, 0, 0, ex);
    check(wiper == mw(), "R6 data to wiper", wiper, mw());

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [3:0] op;
      logic [1:0] r, p;
      logic [7:0] d;
      int k;
      k = $urandom_range(0, 6);
      r = 2'($urandom); p = 2'($urandom); d = 8'($urandom);
      wp_n = ($urandom_range(0, 7) != 0);
      if (k == 6) begin
        step(p, $urandom_range(1, 8), $urandom);
        check(wiper == mw(), "R7 random step", wiper, mw());
      end else begin
        op = (k == 0) ? 4'h9 : (k == 1) ? 4'hA : (k == 2) ? 4'hB :
             (k == 3) ? 4'hC : (k == 4) ? 4'hD : 4'hE;
        cmd(op, r, p, d, ADDR, rd);
        model(op, r, p, d, ex);
        if (op == 4'h9 || op == 4'hB) check(rd == ex, "R5 random read", rd, ex);
        else check(wiper == mw(), "R2 random command", wiper, mw());
        if ((op == 4'hC || op == 4'hE) && wp_n) repeat (BUSY + 5) @(negedge clk);
      end
    end
    wp_n = 1;
    // R6 wiper to data register checked via read
    cmd(4'hE, 2'd1, 2'd2, 0, ADDR, rd); model(4'hE, 1, 2, 0, ex);
    repeat (BUSY + 5) @(negedge clk);
    cmd(4'hB, 2'd1, 2'd2, 0, ADDR, rd);
    check(rd == m_d[2][1], "R6 wiper to data", rd, m_d[2][1]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule